// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupts for a small 8-bit processor core. Eleven maskable sources feed it. Eight are internal pulses: four timer overflows, a serial transfer done, a display-complete event, a vertical-sync event and a built-in periodic tick. The other three are external pins, each of which can be set to react to either edge. A software-break request and the reset itself are non-maskable and sit at the two ends of the priority order.

Each maskable source has a request bit and an enable bit. Both are reachable through a small register bus, along with the pin polarity and a tick stop control. The processor supplies its interrupt-disable flag. When a source wins, the block raises a one-cycle accept strobe and presents that source's 16-bit vector address. The processor takes the strobe as its order to set the disable flag, and the block clears the served request bit at the same clock edge.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst_n` is low, and during the first cycle after it is released, `accept` is 1 and `vector` is 16'hFFFE. All request, enable, polarity and stop bits reset to 0.
- R2: A one-cycle pulse on an internal source sets its request bit at the next clock edge. Request bits live at address 0 and address 1. Address 0 holds: bit0 display, bit1 pin1, bit2 pin0, bit3 tmr_ovf[3], bit4 tick, bit5 vsync, bit6 tmr_ovf[2], bit7 tmr_ovf[1]. Address 1 holds: bit0 tmr_ovf[0], bit1 serial, bit2 pin2.
- R3: Each external pin passes through two synchronizing flops. The edge detector then sets the pin's request bit at the third clock edge after the pin changes. The polarity register at address 4 has bit 3 for pin0, bit 4 for pin1 and bit 5 for pin2. A polarity bit of 0 selects the low-to-high edge and 1 selects the high-to-low edge. The other edge has no effect.
- R4: Writing 0 to a request bit clears it. Writing 1 leaves it unchanged. If a source event lands in the same cycle as a clear, the bit stays set.
- R5: The enable bits sit at address 2 and address 3, in the same layout as the request bits. They can be written to 0 or 1.
- R6: A maskable source is accepted only when its request bit is 1, its enable bit is 1 and `irq_disable` is 0. Acceptance is decided combinationally in that cycle. The winner's request bit is cleared at the next edge unless a new event for that source arrives in the same cycle.
- R7: Among eligible maskable sources, the lower bit index wins, with address 0 before address 1. The vectors from index 0 to index 10 are FFFC, FFFA, FFF8, FFF4, FFF2, FFF0, FFEE, FFEC, FFEA, FFE8 and FFE4 (hex).
- R8: A `brk_req` pulse leaves a pending break. The break is accepted with vector FFDE regardless of enables and `irq_disable`, but only in a cycle where no maskable source is eligible and R1 does not apply.
- R9: The tick source fires once every TICK_DIV (4096) cycles. Writing bit 0 of address 5 to 1 stops the tick and resets its count. When 0 is written back, the first tick comes in the 4096th cycle after that write edge.
- R10: Reads are combinational. Unused bits and unused addresses read as 0. Address 4 reads its polarity bits in place, and address 5 reads the stop bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tmr_ovf | input | 4 | Timer overflow pulses |
| sio_done | input | 1 | Serial transfer done pulse |
| disp_done | input | 1 | Display-complete pulse |
| vsync | input | 1 | Vertical-sync pulse |
| ext_pin | input | 3 | External interrupt pins |
| brk_req | input | 1 | Software break pulse |
| irq_disable | input | 1 | Processor interrupt-disable flag |
| accept | output | 1 | Interrupt accept strobe |
| vector | output | 16 | Vector address of the accepted source |

## Verification
The delicate case is a hardware event that lands on the same request bit in the cycle that bit is being cleared. That clear can come from a software write of 0 or from the acceptance of that very source. The bench forces both cases by raising the pulse in the exact cycle of the write, or in the cycle where the accept strobe is expected. It then reads the register back to confirm the bit survived. A behavioural model advanced every clock judges accept, vector and read data throughout, so any cycle where the clear wrongly beats the event shows up both in the compare and in the readback.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int TICK_DIV = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [3:0]  tmr_ovf,
  input  logic        sio_done,
  input  logic        disp_done,
  input  logic        vsync,
  input  logic [2:0]  ext_pin,
  input  logic        brk_req,
  input  logic        irq_disable,
  output logic        accept,
  output logic [15:0] vector
);
  localparam int NSRC = 11;
  localparam int NPIN = 3;
  localparam int CW   = $clog2(TICK_DIV);

  logic [NSRC-1:0] req, en, ev, elig, grant, wr_clr;
  logic [NPIN-1:0] pol, s1, s2, s3, pin_ev;
  logic [CW-1:0]   cnt;
  logic            ctl_stop, boot, brk_pend, brk_take, tick;

  function automatic logic [15:0] vec_of(input int i);
    case (i)
      0: vec_of = 16'hFFFC;
      1: vec_of = 16'hFFFA;
      2: vec_of = 16'hFFF8;
      3: vec_of = 16'hFFF4;
      4: vec_of = 16'hFFF2;
      5: vec_of = 16'hFFF0;
      6: vec_of = 16'hFFEE;
      7: vec_of = 16'hFFEC;
      8: vec_of = 16'hFFEA;
      9: vec_of = 16'hFFE8;
      default: vec_of = 16'hFFE4;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s3, s2, s1} <= '0;
    else        {s3, s2, s1} <= {s2, s1, ext_pin};

  for (genvar k = 0; k < NPIN; k++) begin : g_edge
    assign pin_ev[k] = pol[k] ? (s3[k] & ~s2[k]) : (s2[k] & ~s3[k]);
  end

  assign tick = !ctl_stop && (cnt == CW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cnt <= '0;
    else if (ctl_stop) cnt <= '0;
    else               cnt <= tick ? '0 : cnt + CW'(1);

  assign ev = {pin_ev[2], sio_done, tmr_ovf[0], tmr_ovf[1], tmr_ovf[2],
               vsync, tick, tmr_ovf[3], pin_ev[0], pin_ev[1], disp_done};

  assign elig = boot ? '0 : (req & en & {NSRC{~irq_disable}});

  always_comb begin
    grant = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
  end

  assign brk_take = !boot && (elig == '0) && brk_pend;
  assign accept   = boot | (|elig) | brk_take;

  always_comb begin
    vector = brk_take ? 16'hFFDE : 16'h0000;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) vector = vec_of(i);
    if (boot) vector = 16'hFFFE;
  end

  always_comb begin
    wr_clr = '0;
    if (reg_we && reg_addr == 3'd0) wr_clr[7:0]  = ~reg_wdata;
    if (reg_we && reg_addr == 3'd1) wr_clr[10:8] = ~reg_wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req      <= '0;
      en       <= '0;
      pol      <= '0;
      ctl_stop <= 1'b0;
      boot     <= 1'b1;
      brk_pend <= 1'b0;
    end else begin
      req      <= (req & ~wr_clr & ~grant) | ev;
      boot     <= 1'b0;
      brk_pend <= (brk_pend & ~brk_take) | brk_req;
      if (reg_we && reg_addr == 3'd2) en[7:0]  <= reg_wdata;
      if (reg_we && reg_addr == 3'd3) en[10:8] <= reg_wdata[2:0];
      if (reg_we && reg_addr == 3'd4) pol      <= reg_wdata[5:3];
      if (reg_we && reg_addr == 3'd5) ctl_stop <= reg_wdata[0];
    end

  always_comb
    case (reg_addr)
      3'd0:    reg_rdata = req[7:0];
      3'd1:    reg_rdata = {5'b0, req[10:8]};
      3'd2:    reg_rdata = en[7:0];
      3'd3:    reg_rdata = {5'b0, en[10:8]};
      3'd4:    reg_rdata = {2'b0, pol, 3'b0};
      3'd5:    reg_rdata = {7'b0, ctl_stop};
      default: reg_rdata = 8'h00;
    endcase
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic [15:0] vector,
  input logic        idis,
  input logic [10:0] req,
  input logic [10:0] en,
  input logic [10:0] ev,
  input logic [10:0] grant,
  input logic        ctl_stop,
  input logic        tick
);
  // R6
  masked_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && vector != 16'hFFFE && vector != 16'hFFDE) |-> !idis);

  // R6
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6
  served_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && ((grant & ev) == '0)) |=> ((req & $past(grant)) == '0));

  // R4
  no_soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == '0) |=> ((req & ~$past(req)) == '0));

  // R8
  brk_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((req & en) != '0) && !idis) |-> (vector != 16'hFFDE));

  // R9
  tick_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stop |-> !tick);
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .vector(vector),
  .idis(irq_disable), .req(req), .en(en), .ev(ev), .grant(grant),
  .ctl_stop(ctl_stop), .tick(tick)
);

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  localparam int TICK_DIV = 4096;

  logic clk = 0, rst_n = 0, reg_we = 0, sio_done = 0, disp_done = 0, vsync = 0;
  logic brk_req = 0, irq_disable, accept, cli = 0;
  logic [2:0] reg_addr = 0, ext_pin = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [3:0] tmr_ovf = 0;
  logic [15:0] vector;
  int n_chk = 0, n_fail = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  irq_arbiter #(.TICK_DIV(TICK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_ovf(tmr_ovf),
    .sio_done(sio_done), .disp_done(disp_done), .vsync(vsync),
    .ext_pin(ext_pin), .brk_req(brk_req), .irq_disable(irq_disable),
    .accept(accept), .vector(vector));

  logic [10:0] m_req, m_en;
  logic [2:0]  m_pol;
  logic        m_stop, m_boot, m_brk;
  int          m_cnt;
  logic [2:0]  ph[$];
  logic [15:0] vtab [12] = '{16'hFFFC, 16'hFFFA, 16'hFFF8, 16'hFFF4, 16'hFFF2, 16'hFFF0,
                             16'hFFEE, 16'hFFEC, 16'hFFEA, 16'hFFE8, 16'hFFE4, 16'hFFDE};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_win();
    if (m_boot) return 12;
    for (int i = 0; i < 11; i++)
      if (m_req[i] && m_en[i] && !irq_disable) return i;
    if (m_brk) return 11;
    return -1;
  endfunction

  function automatic logic [7:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_req[7:0];
      3'd1: return {5'b0, m_req[10:8]};
      3'd2: return m_en[7:0];
      3'd3: return {5'b0, m_en[10:8]};
      3'd4: return {2'b0, m_pol, 3'b0};
      3'd5: return {7'b0, m_stop};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int w;
    logic [10:0] e;
    logic [2:0] pe;
    started = 1;
    if (!rst_n) begin
      m_req = 0; m_en = 0; m_pol = 0; m_stop = 0; m_boot = 1; m_brk = 0; m_cnt = 0;
      ph = '{3'b0, 3'b0, 3'b0};
      irq_disable <= 1'b1;
    end else begin
      w = m_win();
      for (int k = 0; k < 3; k++)
        pe[k] = m_pol[k] ? (ph[2][k] && !ph[1][k]) : (ph[1][k] && !ph[2][k]);
      e = '0;
      e[0] = disp_done; e[1] = pe[1]; e[2] = pe[0]; e[3] = tmr_ovf[3];
      e[4] = !m_stop && (m_cnt == TICK_DIV - 1);
      e[5] = vsync; e[6] = tmr_ovf[2]; e[7] = tmr_ovf[1]; e[8] = tmr_ovf[0];
      e[9] = sio_done; e[10] = pe[2];
      for (int i = 0; i < 11; i++) begin
        if (reg_we && reg_addr == 0 && i < 8 && !reg_wdata[i]) m_req[i] = 0;
        if (reg_we && reg_addr == 1 && i >= 8 && !reg_wdata[i-8]) m_req[i] = 0;
        if (w == i) m_req[i] = 0;
        if (e[i]) m_req[i] = 1;
      end
      if (reg_we && reg_addr == 2) m_en[7:0] = reg_wdata;
      if (reg_we && reg_addr == 3) m_en[10:8] = reg_wdata[2:0];
      if (reg_we && reg_addr == 4) m_pol = reg_wdata[5:3];
      m_cnt = m_stop ? 0 : ((m_cnt == TICK_DIV - 1) ? 0 : m_cnt + 1);
      if (reg_we && reg_addr == 5) m_stop = reg_wdata[0];
      if (w == 11) m_brk = 0;
      if (brk_req) m_brk = 1;
      m_boot = 0;
      ph.push_front(ext_pin);
      void'(ph.pop_back());
      irq_disable <= (w >= 0) ? 1'b1 : (cli ? 1'b0 : irq_disable);
    end
  end

  always @(negedge clk) begin : compare
    int w;
    if (started) begin
      w = m_win();
      chk("R6 accept vs model", int'(accept), int'(w >= 0));
      if (w == 12) chk("R1 vector vs model", vector, 16'hFFFE);
      else if (w >= 0) chk("R7 vector vs model", vector, vtab[w]);
      chk("R10 rdata vs model", reg_rdata, m_rd(reg_addr));
    end
  end

  task automatic clr();
    tmr_ovf = 0; sio_done = 0; disp_done = 0; vsync = 0; brk_req = 0; cli = 0; reg_we = 0;
  endtask
  task automatic cyc();
    @(posedge clk); #1; clr();
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; cyc();
  endtask
  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; @(negedge clk); chk(tag, reg_rdata, exp); cyc();
  endtask
  task automatic acc(input logic [15:0] exp, input string tag);
    @(negedge clk); chk(tag, int'(accept), 1); chk(tag, vector, exp); cyc();
  endtask
  task automatic nacc(input string tag);
    @(negedge clk); chk(tag, int'(accept), 0); cyc();
  endtask
  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk("R1 accept in reset", int'(accept), 1);
    chk("R1 vector in reset", vector, 16'hFFFE);
    @(posedge clk); #1; rst_n = 1;
    acc(16'hFFFE, "R1 first cycle after reset");
    for (int a = 0; a < 8; a++) rd(a[2:0], 8'h00, "R1 R10 register reset");

    tmr_ovf = 4'hF; sio_done = 1; disp_done = 1; vsync = 1; cyc();
    rd(0, 8'hE9, "R2 request low");
    rd(1, 8'h03, "R2 request high");

    wr(0, 8'hFF); rd(0, 8'hE9, "R4 write one no set");
    wr(0, 8'hFE); rd(0, 8'hE8, "R4 clear bit0");
    disp_done = 1; wr(0, 8'h00); rd(0, 8'h01, "R4 event beats clear");
    wr(1, 8'h00); rd(1, 8'h00, "R4 clear high");
    wr(0, 8'h00); rd(0, 8'h00, "R4 clear low");

    wr(2, 8'hA5); rd(2, 8'hA5, "R5 enable low");
    wr(3, 8'hFF); rd(3, 8'h07, "R5 R10 enable high");
    wr(2, 8'h00); rd(2, 8'h00, "R5 enable cleared");

    wr(2, 8'hFF); wr(3, 8'h07);
    disp_done = 1; tmr_ovf = 4'hF; vsync = 1; cyc();
    nacc("R6 disable flag blocks");
    cli = 1; cyc(); acc(16'hFFFC, "R7 display first");
    cli = 1; cyc(); acc(16'hFFF4, "R7 tmr3 second");
    cli = 1; cyc(); acc(16'hFFF0, "R7 vsync third");
    cli = 1; cyc(); acc(16'hFFEE, "R7 tmr2");
    cli = 1; cyc(); acc(16'hFFEC, "R7 tmr1");
    cli = 1; cyc(); tmr_ovf = 4'b0001; acc(16'hFFEA, "R6 tmr0 served with event");
    rd(1, 8'h01, "R6 event survives accept clear");
    wr(1, 8'h00);

    brk_req = 1; cyc(); acc(16'hFFDE, "R8 break ignores disable");
    sio_done = 1; brk_req = 1; cli = 1; cyc();
    acc(16'hFFE8, "R8 serial before break");
    acc(16'hFFDE, "R8 break after serial");
    wr(2, 8'h00); wr(3, 8'h00);
    brk_req = 1; cyc(); acc(16'hFFDE, "R8 break ignores enable");

    ext_pin = 3'b001; cyc(); cyc();
    rd(0, 8'h00, "R3 latency not yet");
    rd(0, 8'h04, "R3 pin0 rising");
    wr(0, 8'h00);
    wr(4, 8'h10); rd(4, 8'h10, "R3 R10 polarity readback");
    ext_pin = 3'b011; repeat (4) cyc();
    rd(0, 8'h00, "R3 rising ignored on falling pin");
    ext_pin = 3'b001; repeat (4) cyc();
    rd(0, 8'h02, "R3 pin1 falling");
    ext_pin = 3'b101; repeat (4) cyc();
    rd(1, 8'h04, "R3 pin2 rising");
    ext_pin = 3'b100; repeat (4) cyc();
    rd(0, 8'h02, "R3 pin0 falling ignored");
    wr(0, 8'h00); wr(1, 8'h00);

    wr(5, 8'h01); wr(0, 8'h00);
    rd(5, 8'h01, "R9 R10 stop readback");
    wr(5, 8'h00);
    repeat (TICK_DIV - 1) cyc();
    rd(0, 8'h00, "R9 tick not yet");
    rd(0, 8'h10, "R9 tick period");
    wr(5, 8'h01); wr(0, 8'h00);
    repeat (5000) cyc();
    rd(0, 8'h00, "R9 stopped tick");

    summary();
    $finish;
  end
endmodule